// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital half of a dual-slope integrating analog-to-digital converter built for inputs that swing both above and below mid-scale. It owns a single counter and a small phase machine. After reset, and for as long as the start enable stays high, it loops through three steps. First it zeroes the integrator. Then it integrates the input for a fixed window. Last it ramps the integrator back with a reference until the comparator flips. The analog integrator, the comparator and the switches sit outside the block. The block drives the switch enables and reads one comparator bit.

The input polarity is resolved inside the conversion itself. When the fixed window closes, the block latches the comparator level as a sign bit. That bit chooses which reference is used for the run-down: ground or full scale. The run-down count becomes the magnitude and the latched bit becomes the sign, so a single conversion covers both polarities. A run-down that never trips is cut off and reported as full scale.

Top module: `dsadc_sequencer`

## Requirements
- R1: While reset is held, every switch enable is low and `done`, `result` and `sign` are zero. With `start_en` high after reset, the phases follow the order auto-zero, then integrate, then run-down, and each phase starts right after the one before it.
- R2: The auto-zero phase keeps `sw_azero` high for exactly AZ_CYCLES clock cycles (default 100), with every other switch open.
- R3: The integrate phase keeps `sw_input` high for exactly 2^RES_BITS cycles (default 2^14), counted from a counter that restarts at zero.
- R4: When the integrate window ends, the synchronized comparator level is latched as the sign bit (1 = integrator above mid-scale). It does not change during the run-down. It appears on `sign` together with `done`.
- R5: During run-down, sign 1 closes `sw_ref_gnd` and sign 0 closes `sw_ref_full`. At most one switch enable is ever high.
- R6: The run-down count starts at zero and stops at the first cycle in which the synchronized comparator differs from the latched sign. That count is loaded into `result`.
- R7: `done` is a single-cycle pulse. `result` and `sign` change only in the cycle that `done` is high, and hold their values until the next pulse.
- R8: If the run-down count reaches 2^RES_BITS-1 without a trip, `result` is loaded with all ones and `done` still pulses.
- R9: If `start_en` is low when a conversion ends, the block idles with all switches open and no `done` pulse. It starts auto-zero on the clock edge after `start_en` returns high.
- R10: `cmp_in` passes through a two-stage synchronizer before use. A comparator change therefore takes effect two clocks after it reaches the pin, and this delay adds to the run-down count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_en | input | 1 | Keep converting while high; idle after the current conversion while low |
| cmp_in | input | 1 | Raw comparator output, 1 when the integrator is above mid-scale |
| sw_azero | output | 1 | Close the auto-zero switches |
| sw_input | output | 1 | Connect the input to the integrator |
| sw_ref_full | output | 1 | Connect the full-scale reference for run-down |
| sw_ref_gnd | output | 1 | Connect the ground reference for run-down |
| done | output | 1 | One-cycle end-of-conversion pulse |
| result | output | RES_BITS | Run-down count of the last conversion |
| sign | output | 1 | Polarity of the last conversion |

## Verification
The bench closes the loop with an integer integrator ramp driven by the block's own switch outputs. It runs positive, negative and zero inputs, and inputs large enough to hit the run-down timeout. A cycle-level reference model is compared on every clock. An off-by-one in either fixed phase shows up as a wrong phase length. A sign taken from the raw pin, or taken one cycle off, picks the wrong reference and the ramp runs away into a timeout. A missing or extra synchronizer stage shifts every result by one count. Dropping `start_en` checks that the block parks with its switches open and that the last result stays in place.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_AZERO = 2'd1,
        PH_INTEG = 2'd2,
        PH_DEINT = 2'd3
    } phase_e;

endpackage

// File: rtl/dsadc_sync.sv
module dsadc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] sync_d, sync_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb sync_d = din;
        end else begin : g_chain
            always_comb sync_d = {sync_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign dout = sync_q[STAGES-1];

endmodule

// File: rtl/dsadc_counter.sv
// Shared phase counter: W bits of count plus a carry-out that marks the wrap.
module dsadc_counter #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count,
    output logic         carry
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)      cnt_d = '0;
        else if (inc) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
    assign carry = inc & (&cnt_q);

endmodule

// File: rtl/dsadc_switch_dec.sv
module dsadc_switch_dec
    import dsadc_pkg::*;
(
    input  phase_e phase,
    input  logic   sign_lat,
    output logic   sw_azero,
    output logic   sw_input,
    output logic   sw_ref_full,
    output logic   sw_ref_gnd
);

    always_comb begin
        sw_azero    = 1'b0;
        sw_input    = 1'b0;
        sw_ref_full = 1'b0;
        sw_ref_gnd  = 1'b0;
        unique case (phase)
            PH_AZERO: sw_azero = 1'b1;
            PH_INTEG: sw_input = 1'b1;
            PH_DEINT: begin
                // integrator above mid-scale is pulled down by ground, below by full scale
                if (sign_lat) sw_ref_gnd  = 1'b1;
                else          sw_ref_full = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dsadc_fsm.sv
module dsadc_fsm
    import dsadc_pkg::*;
#(
    parameter int RES_BITS  = 14,
    parameter int AZ_CYCLES = 100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_en,
    input  logic                cmp_s,
    input  logic [RES_BITS-1:0] cnt,
    input  logic                carry,
    output logic                cnt_clr,
    output logic                cnt_inc,
    output phase_e              phase,
    output logic                sign_lat,
    output logic                done,
    output logic [RES_BITS-1:0] result,
    output logic                sign
);

    localparam logic [RES_BITS-1:0] AZ_LAST  = RES_BITS'(AZ_CYCLES - 1);
    localparam logic [RES_BITS-1:0] FULL_SCL = '1;

    typedef struct packed {
        phase_e              phase;
        logic                sign_lat;
        logic                done;
        logic [RES_BITS-1:0] result;
        logic                sign;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic       finish;
    logic [RES_BITS-1:0] capture;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        cnt_clr   = 1'b0;
        cnt_inc   = 1'b0;
        finish    = 1'b0;
        capture   = cnt;
        unique case (st_q.phase)
            PH_IDLE: begin
                cnt_clr = 1'b1;
                if (start_en) st_d.phase = PH_AZERO;
            end
            PH_AZERO: begin
                if (cnt == AZ_LAST) begin
                    cnt_clr    = 1'b1;
                    st_d.phase = PH_INTEG;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            PH_INTEG: begin
                cnt_inc = 1'b1;
                if (carry) begin
                    cnt_clr       = 1'b1;
                    st_d.phase    = PH_DEINT;
                    st_d.sign_lat = cmp_s;
                end
            end
            PH_DEINT: begin
                cnt_inc = 1'b1;
                if (cmp_s != st_q.sign_lat) begin
                    finish  = 1'b1;
                    capture = cnt;
                end else if (carry) begin
                    finish  = 1'b1;
                    capture = FULL_SCL;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase

        if (finish) begin
            cnt_clr     = 1'b1;
            st_d.done   = 1'b1;
            st_d.result = capture;
            st_d.sign   = st_q.sign_lat;
            st_d.phase  = start_en ? PH_AZERO : PH_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase    <= PH_IDLE;
            st_q.sign_lat <= 1'b0;
            st_q.done     <= 1'b0;
            st_q.result   <= '0;
            st_q.sign     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase    = st_q.phase;
    assign sign_lat = st_q.sign_lat;
    assign done     = st_q.done;
    assign result   = st_q.result;
    assign sign     = st_q.sign;

    AST_INT_STARTS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_INTEG && $past(st_q.phase) == PH_AZERO) |-> (cnt == '0)); // R3

    AST_SIGN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_DEINT && $past(st_q.phase) == PH_DEINT) |-> $stable(st_q.sign_lat)); // R4

    AST_DONE_AFTER_RUNDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> ($past(st_q.phase) == PH_DEINT)); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done); // R7

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.done |-> ($stable(st_q.result) && $stable(st_q.sign))); // R7

    AST_TIMEOUT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && $past(cnt) == FULL_SCL && $past(cmp_s) == $past(st_q.sign_lat))
        |-> (st_q.result == FULL_SCL)); // R8

    AST_PARK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_IDLE && !start_en) |=> (st_q.phase == PH_IDLE)); // R9

endmodule

// File: rtl/dsadc_sequencer.sv
module dsadc_sequencer
    import dsadc_pkg::*;
#(
    parameter int RES_BITS    = 14,
    parameter int AZ_CYCLES   = 100,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_en,
    input  logic                cmp_in,
    output logic                sw_azero,
    output logic                sw_input,
    output logic                sw_ref_full,
    output logic                sw_ref_gnd,
    output logic                done,
    output logic [RES_BITS-1:0] result,
    output logic                sign
);

    logic                cmp_s;
    logic [RES_BITS-1:0] cnt;
    logic                carry;
    logic                cnt_clr;
    logic                cnt_inc;
    phase_e              phase;
    logic                sign_lat;

    dsadc_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (cmp_in),
        .dout  (cmp_s)
    );

    dsadc_counter #(.W(RES_BITS)) i_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .count (cnt),
        .carry (carry)
    );

    dsadc_fsm #(.RES_BITS(RES_BITS), .AZ_CYCLES(AZ_CYCLES)) i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_en (start_en),
        .cmp_s    (cmp_s),
        .cnt      (cnt),
        .carry    (carry),
        .cnt_clr  (cnt_clr),
        .cnt_inc  (cnt_inc),
        .phase    (phase),
        .sign_lat (sign_lat),
        .done     (done),
        .result   (result),
        .sign     (sign)
    );

    dsadc_switch_dec i_swdec (
        .phase       (phase),
        .sign_lat    (sign_lat),
        .sw_azero    (sw_azero),
        .sw_input    (sw_input),
        .sw_ref_full (sw_ref_full),
        .sw_ref_gnd  (sw_ref_gnd)
    );

    AST_ONE_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sw_azero, sw_input, sw_ref_full, sw_ref_gnd})); // R5

    AST_AZ_THEN_INT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_azero) |-> sw_input); // R1

    AST_INT_THEN_REF: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_input) |-> (sw_ref_full || sw_ref_gnd)); // R1

endmodule

// File: tb/test_dsadc_sequencer.sv
module test_dsadc_sequencer;

    localparam int RB    = 8;
    localparam int AZC   = 100;
    localparam int SLOPE = 16;
    localparam int FULL  = (1 << RB) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_en = 1'b1;
    logic cmp_in = 1'b0;
    logic sw_azero, sw_input, sw_ref_full, sw_ref_gnd, done, sign;
    logic [RB-1:0] result;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    int vin = 0;
    int integ = 0;

    // reference model state
    int m_ph = 0, m_cnt = 0, m_s1 = 0, m_s2 = 0, m_slat = 0;
    int m_res = 0, m_sign = 0, m_done = 0;
    // phase length trackers
    int az_run = 0, in_run = 0, prev_az = 0, prev_in = 0;

    always #2.5 clk = ~clk;

    dsadc_sequencer #(.RES_BITS(RB), .AZ_CYCLES(AZC), .SYNC_STAGES(2)) i_dsadc_sequencer (
        .clk(clk), .rst_n(rst_n), .start_en(start_en), .cmp_in(cmp_in),
        .sw_azero(sw_azero), .sw_input(sw_input), .sw_ref_full(sw_ref_full),
        .sw_ref_gnd(sw_ref_gnd), .done(done), .result(result), .sign(sign)
    );

    task automatic chk(input string tag, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    // behavioural cycle model of the requirements
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_s1 = 0; m_s2 = 0; m_slat = 0;
            m_res = 0; m_sign = 0; m_done = 0;
        end else begin
            int cs;
            int fin;
            int cap;
            cs = m_s2;            // R10: two-stage delay
            m_s2 = m_s1;
            m_s1 = cmp_in;
            m_done = 0;
            fin = 0;
            cap = 0;
            case (m_ph)
                0: begin m_cnt = 0; if (start_en) m_ph = 1; end
                1: if (m_cnt == AZC - 1) begin m_cnt = 0; m_ph = 2; end else m_cnt++;
                2: if (m_cnt == FULL) begin m_cnt = 0; m_ph = 3; m_slat = cs; end else m_cnt++;
                default: begin
                    if (cs != m_slat) begin fin = 1; cap = m_cnt; end
                    else if (m_cnt == FULL) begin fin = 1; cap = FULL; end
                    else m_cnt++;
                end
            endcase
            if (fin) begin
                m_done = 1; m_res = cap; m_sign = m_slat; m_cnt = 0;
                m_ph = start_en ? 1 : 0;
            end
        end
    end

    // compare on every clock, then advance the analog ramp
    always @(negedge clk) begin
        if (rst_n) begin
            cycles++;
            chk("R2 sw_azero",    int'(sw_azero),    int'(m_ph == 1));
            chk("R3 sw_input",    int'(sw_input),    int'(m_ph == 2));
            chk("R5 sw_ref_full", int'(sw_ref_full), int'(m_ph == 3 && m_slat == 0));
            chk("R5 sw_ref_gnd",  int'(sw_ref_gnd),  int'(m_ph == 3 && m_slat == 1));
            chk("R7 done",        int'(done),        m_done);
            chk("R6 result",      int'(result),      m_res);
            chk("R4 sign",        int'(sign),        m_sign);

            if (sw_azero) az_run++;
            else if (prev_az) begin
                chk("R2 auto-zero length", az_run, AZC);
                chk("R1 integrate follows auto-zero", int'(sw_input), 1);
                az_run = 0;
            end
            if (sw_input) in_run++;
            else if (prev_in) begin
                chk("R3 integrate length", in_run, 1 << RB);
                chk("R1 run-down follows integrate", int'(sw_ref_full | sw_ref_gnd), 1);
                in_run = 0;
            end
            prev_az = sw_azero;
            prev_in = sw_input;

            if (sw_azero)         integ = 0;
            else if (sw_input)    integ += vin;
            else if (sw_ref_full) integ += SLOPE;
            else if (sw_ref_gnd)  integ -= SLOPE;
            cmp_in = (integ > 0);
        end
        if (cycles > 100000) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog expired actual=%0d expected=done", cycles);
            finish_run();
        end
    end

    task automatic convert(input int v, input int exp_sign, input int exp_mag, input int tol);
        int diff;
        vin = v;
        do @(negedge clk); while (!done);
        #1;
        chk("R4 sign of conversion", int'(sign), exp_sign);
        diff = int'(result) - exp_mag;
        if (diff < 0) diff = -diff;
        if (tol == 0) chk("R8 timeout gives full scale", int'(result), exp_mag);
        else chk("R6 magnitude within tolerance", int'(diff <= tol), 1);
        @(negedge clk);
        chk("R7 done is one cycle", int'(done), 0);
    endtask

    initial begin
        int held;
        repeat (3) @(negedge clk);
        chk("R1 reset switches", int'({sw_azero, sw_input, sw_ref_full, sw_ref_gnd}), 0);
        chk("R1 reset done", int'(done), 0);
        chk("R1 reset result", int'(result), 0);
        chk("R1 reset sign", int'(sign), 0);
        rst_n = 1'b1;

        convert(10, 1, 160, 4);     // positive, ground reference
        convert(-7, 0, 112, 4);     // negative, full-scale reference
        convert(0, 0, 0, 4);        // zero input trips almost at once
        convert(40, 1, FULL, 0);    // R8 positive overrange
        convert(-20, 0, FULL, 0);   // R8 negative overrange

        // R9: drop the enable during a conversion
        vin = 5;
        start_en = 1'b0;
        do @(negedge clk); while (!done);
        #1;
        held = int'(result);
        repeat (40) begin
            @(negedge clk);
            chk("R9 idle switches open", int'({sw_azero, sw_input, sw_ref_full, sw_ref_gnd}), 0);
            chk("R9 no done while idle", int'(done), 0);
        end
        chk("R7 result held while idle", int'(result), held);
        start_en = 1'b1;
        @(negedge clk);
        chk("R9 restart enters auto-zero", int'(sw_azero), 1);
        convert(-3, 0, 48, 4);

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule